// File: doc/BRIEF.md
# Cache-Cluster Performance Counter Bank

This block counts activity for one cache cluster. It holds a parameterised number of 32-bit event counters and one 64-bit cycle counter. Software reaches all of them through a plain register port: one address, one write strobe, write data and combinational read data. Each event counter advances on its own external increment strobe. The cycle counter advances on every clock while it is allowed to run.

Three 32-bit masks decide how each counter behaves: which counters run, which counters may interrupt, and which counters have overflowed. No mask is ever written directly. Software changes a mask only through a pair of addresses, one where each written 1 sets a bit and one where each written 1 clears a bit. In every mask, event counter i owns bit i and the cycle counter owns bit 31. A control register holds the bank-wide run bit, carries two self-clearing reset commands, and reports how many event counters the bank has.

When a counter wraps past all ones, its overflow bit is set. A level interrupt is raised while any overflowed counter also has its interrupt enabled. A typical driver preloads a counter with a value such as 0x8000_0000, takes the interrupt, and then reads and reloads that counter.

Top module: `perf_counter_bank`

## Requirements
- R1: Control register (address 0x400) bit 0 is the bank-wide run bit. Writing 0 to it stops all counting. A read returns the run bit in bit 0, the number of event counters in bits 15:11, and zero in every other bit.
- R2: A control write with bit 1 set zeroes every event counter. A control write with bit 2 set zeroes the cycle counter. Both take effect at the clock edge of the write and win over counting in that cycle. Bits 1 and 2 always read back as 0.
- R3: In the run, interrupt-enable and overflow masks, event counter i uses bit i and the cycle counter uses bit 31. Bits belonging to no counter always read 0 and ignore writes.
- R4: Each mask has a set address and a clear address: run mask 0x404 and 0x403, interrupt-enable mask 0x406 and 0x405, overflow mask 0x408 and 0x407. A written 1 sets the bit at the set address and clears it at the clear address. A written 0 leaves the bit unchanged. Reading either address of a pair returns the current mask.
- R5: Event counter i is read and written at address 0x421 + 0x10*i. A write preloads the counter, and the new value reads back after the write.
- R6: The 64-bit cycle counter has its low word at 0x40A and its high word at 0x40B. Both words are writable. The counter adds one per clock while the run bit and mask bit 31 are both set, and it holds otherwise.
- R7: Event counter i adds one in each clock cycle where its strobe is high, the run bit is set and run-mask bit i is set. In every other cycle it holds its value.
- R8: A counter that wraps from all ones to zero sets its overflow bit at the same edge. This holds even when software writes that bit's clear address in the same cycle.
- R9: The interrupt output is high exactly while some counter has both its overflow bit and its interrupt-enable bit set.
- R10: Reads of addresses that map to no register return 0, and writes to them change nothing.
- R11: After reset all counters, all masks and the run bit are zero, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_inc | input | NUM_EVC | Per-counter increment strobes |
| ovf_irq | output | 1 | Level overflow interrupt |

## Verification
Every register, including each counter, takes a write at the clock edge where reg_wr is high. Read data is a combinational view of that state, so a value written or counted at an edge can be read half a clock later. The bench therefore drives at the falling edge and samples one time unit after it.

A strobe held for n falling-edge intervals adds exactly n, one per rising edge. The interrupt follows a mask change within the same half clock. For the cycle counter, the run bit is written at one edge and cleared four edges later. That gives exactly four increments, because the edge that clears the run bit still counts.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int DATA_W = 32;

    // register map (12-bit address space)
    localparam logic [11:0] A_CTRL     = 12'h400;
    localparam logic [11:0] A_RUN_CLR  = 12'h403;
    localparam logic [11:0] A_RUN_SET  = 12'h404;
    localparam logic [11:0] A_IE_CLR   = 12'h405;
    localparam logic [11:0] A_IE_SET   = 12'h406;
    localparam logic [11:0] A_OVF_CLR  = 12'h407;
    localparam logic [11:0] A_OVF_SET  = 12'h408;
    localparam logic [11:0] A_CYC_LO   = 12'h40A;
    localparam logic [11:0] A_CYC_HI   = 12'h40B;
    localparam logic [11:0] A_EVC_BASE = 12'h421;
    localparam logic [11:0] A_EVC_STEP = 12'h010;

    // control register fields
    localparam int CTRL_RUN     = 0;
    localparam int CTRL_EV_RST  = 1;
    localparam int CTRL_CY_RST  = 2;
    localparam int CTRL_NUM_LSB = 11;
    localparam int CTRL_NUM_W   = 5;

    // mask bit reserved for the cycle counter
    localparam int CYC_BIT = 31;

    typedef struct packed {
        logic run;
    } ctrl_state_t;

endpackage

// File: rtl/pcb_event_ctr.sv
module pcb_event_ctr
    import pcb_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_ok,
    input  logic         strobe,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } evc_state_t;

    evc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (count_ok && strobe) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;

endmodule

// File: rtl/pcb_cycle_ctr.sv
module pcb_cycle_ctr
    import pcb_pkg::*;
#(
    parameter int CW = 2 * DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            count_ok,
    input  logic            clear,
    input  logic            load_lo,
    input  logic            load_hi,
    input  logic [CW/2-1:0] load_val,
    output logic [CW-1:0]   value,
    output logic            wrap
);

    localparam int HALF = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cyc_state_t;

    cyc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (load_lo || load_hi) begin
            if (load_lo) st_d.cnt[HALF-1:0]  = load_val;
            if (load_hi) st_d.cnt[CW-1:HALF] = load_val;
        end else if (count_ok) begin
            st_d.cnt = st_q.cnt + 1'b1;
            wrap     = &st_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;

endmodule

// File: rtl/pcb_mask_regs.sv
module pcb_mask_regs
    import pcb_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [31:0] PRESENT = 32'h8000_000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [31:0]       hw_ovf,
    output logic [31:0]       run_mask,
    output logic [31:0]       ie_mask,
    output logic [31:0]       ovf_mask
);

    localparam int NMASK = 3;
    localparam logic [11:0] SET_A [NMASK] = '{A_RUN_SET, A_IE_SET, A_OVF_SET};
    localparam logic [11:0] CLR_A [NMASK] = '{A_RUN_CLR, A_IE_CLR, A_OVF_CLR};

    typedef struct packed {
        logic [31:0] bits;
    } mask_state_t;

    logic [31:0] hw_set [NMASK];
    logic [31:0] cur    [NMASK];

    assign hw_set[0] = '0;
    assign hw_set[1] = '0;
    assign hw_set[2] = hw_ovf;

    for (genvar k = 0; k < NMASK; k++) begin : g_mask
        mask_state_t m_d, m_q;
        logic hit_set, hit_clr;

        assign hit_set = wr_en && (addr == ADDR_W'(SET_A[k]));
        assign hit_clr = wr_en && (addr == ADDR_W'(CLR_A[k]));

        always_comb begin
            m_d = m_q;
            if (hit_set) m_d.bits = m_d.bits | (wdata & PRESENT);
            if (hit_clr) m_d.bits = m_d.bits & ~wdata;
            // a hardware overflow event wins over a software clear
            m_d.bits = m_d.bits | (hw_set[k] & PRESENT);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) m_q <= '0;
            else        m_q <= m_d;
        end

        assign cur[k] = m_q.bits;
    end

    assign run_mask = cur[0];
    assign ie_mask  = cur[1];
    assign ovf_mask = cur[2];

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_EVC = 4,
    parameter int EVC_W   = DATA_W,
    parameter int CYC_W   = 2 * DATA_W,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_EVC-1:0] evt_inc,
    output logic               ovf_irq
);

    localparam logic [31:0] PRESENT   = (32'h1 << CYC_BIT) | ((32'h1 << NUM_EVC) - 32'h1);
    localparam logic [CTRL_NUM_W-1:0] NUM_FIELD = CTRL_NUM_W'(NUM_EVC);
    localparam int CYC_HALF = CYC_W / 2;

    function automatic logic [ADDR_W-1:0] evc_addr(input int idx);
        return ADDR_W'(32'(A_EVC_BASE) + 32'(idx) * 32'(A_EVC_STEP));
    endfunction

    // ---------------- control register ----------------
    ctrl_state_t ctrl_d, ctrl_q;
    logic        ev_clr, cy_clr;

    always_comb begin
        ctrl_d = ctrl_q;
        ev_clr = 1'b0;
        cy_clr = 1'b0;
        if (reg_wr && reg_addr == ADDR_W'(A_CTRL)) begin
            ctrl_d.run = reg_wdata[CTRL_RUN];
            ev_clr     = reg_wdata[CTRL_EV_RST];
            cy_clr     = reg_wdata[CTRL_CY_RST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // ---------------- masks ----------------
    logic [31:0] run_mask, ie_mask, ovf_mask, hw_ovf;

    pcb_mask_regs #(
        .ADDR_W (ADDR_W),
        .PRESENT(PRESENT)
    ) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .hw_ovf  (hw_ovf),
        .run_mask(run_mask),
        .ie_mask (ie_mask),
        .ovf_mask(ovf_mask)
    );

    // ---------------- event counters ----------------
    logic [EVC_W-1:0]   ev_val [NUM_EVC];
    logic [NUM_EVC-1:0] ev_wrap;

    for (genvar i = 0; i < NUM_EVC; i++) begin : g_evc
        logic ev_load;
        assign ev_load = reg_wr && (reg_addr == evc_addr(i));

        pcb_event_ctr #(.W(EVC_W)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .count_ok(ctrl_q.run && run_mask[i]),
            .strobe  (evt_inc[i]),
            .clear   (ev_clr),
            .load    (ev_load),
            .load_val(EVC_W'(reg_wdata)),
            .value   (ev_val[i]),
            .wrap    (ev_wrap[i])
        );
    end

    // ---------------- cycle counter ----------------
    logic [CYC_W-1:0] cyc_val;
    logic             cyc_wrap;

    pcb_cycle_ctr #(.CW(CYC_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_ok(ctrl_q.run && run_mask[CYC_BIT]),
        .clear   (cy_clr),
        .load_lo (reg_wr && reg_addr == ADDR_W'(A_CYC_LO)),
        .load_hi (reg_wr && reg_addr == ADDR_W'(A_CYC_HI)),
        .load_val(CYC_HALF'(reg_wdata)),
        .value   (cyc_val),
        .wrap    (cyc_wrap)
    );

    always_comb begin
        hw_ovf = '0;
        for (int i = 0; i < NUM_EVC; i++) hw_ovf[i] = ev_wrap[i];
        hw_ovf[CYC_BIT] = cyc_wrap;
    end

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CTRL)) begin
            reg_rdata[CTRL_RUN] = ctrl_q.run;
            reg_rdata[CTRL_NUM_LSB +: CTRL_NUM_W] = NUM_FIELD;
        end else if (reg_addr == ADDR_W'(A_RUN_SET) || reg_addr == ADDR_W'(A_RUN_CLR)) begin
            reg_rdata = run_mask;
        end else if (reg_addr == ADDR_W'(A_IE_SET) || reg_addr == ADDR_W'(A_IE_CLR)) begin
            reg_rdata = ie_mask;
        end else if (reg_addr == ADDR_W'(A_OVF_SET) || reg_addr == ADDR_W'(A_OVF_CLR)) begin
            reg_rdata = ovf_mask;
        end else if (reg_addr == ADDR_W'(A_CYC_LO)) begin
            reg_rdata = 32'(cyc_val[CYC_HALF-1:0]);
        end else if (reg_addr == ADDR_W'(A_CYC_HI)) begin
            reg_rdata = 32'(cyc_val[CYC_W-1:CYC_HALF]);
        end else begin
            for (int i = 0; i < NUM_EVC; i++) begin
                if (reg_addr == evc_addr(i)) reg_rdata = 32'(ev_val[i]);
            end
        end
    end

    assign ovf_irq = |(ovf_mask & ie_mask);

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int NUM_EVC = 4,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic [NUM_EVC-1:0] evt_inc,
    input logic               ovf_irq,
    input logic               run,
    input logic [31:0]        run_mask,
    input logic [31:0]        ie_mask,
    input logic [31:0]        ovf_mask,
    input logic [31:0]        ev0,
    input logic [63:0]        cyc
);

    logic ev0_touch, cyc_touch;
    assign ev0_touch = reg_wr && (reg_addr == ADDR_W'(12'h421) ||
                       (reg_addr == ADDR_W'(12'h400) && reg_wdata[1]));
    assign cyc_touch = reg_wr && (reg_addr == ADDR_W'(12'h40A) || reg_addr == ADDR_W'(12'h40B) ||
                       (reg_addr == ADDR_W'(12'h400) && reg_wdata[2]));

    // R7
    ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && run_mask[0] && evt_inc[0]) && !ev0_touch) |=> $stable(ev0));

    // R7
    ev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_mask[0] && evt_inc[0] && !ev0_touch) |=> ev0 == $past(ev0) + 32'd1);

    // R8
    ev_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_mask[0] && evt_inc[0] && !ev0_touch && ev0 == 32'hFFFF_FFFF) |=> ovf_mask[0]);

    // R6
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_mask[31] && !cyc_touch) |=> cyc == $past(cyc) + 64'd1);

    // R2
    cyc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(12'h400) && reg_wdata[2]) |=> cyc == 64'd0);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_mask == 32'd0 || ie_mask == 32'd0) |-> !ovf_irq);

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_irq) |-> (ovf_mask & ie_mask) != 32'd0);

    // R10
    hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(12'h409) ||
         (reg_addr >= ADDR_W'(12'h40C) && reg_addr <= ADDR_W'(12'h420))) |-> reg_rdata == 32'd0);

endmodule

bind perf_counter_bank pcb_checker #(
    .NUM_EVC(NUM_EVC),
    .ADDR_W (ADDR_W)
) u_pcb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .evt_inc  (evt_inc),
    .ovf_irq  (ovf_irq),
    .run      (ctrl_q.run),
    .run_mask (run_mask),
    .ie_mask  (ie_mask),
    .ovf_mask (ovf_mask),
    .ev0      (32'(ev_val[0])),
    .cyc      (64'(cyc_val))
);

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] evt_inc = '0;
    logic        ovf_irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_counter_bank #(.NUM_EVC(N)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .evt_inc  (evt_inc),
        .ovf_irq  (ovf_irq)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] ex;
        logic        irq;
    } vec_t;

    // R3 / R4 / R9 mask vectors (absent bits of a 4-counter bank: 30..4)
    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{12'h404, 32'hFFFF_FFFF, 12'h404, 32'h8000_000F, 1'b0},
        '{12'h403, 32'h0000_0005, 12'h403, 32'h8000_000A, 1'b0},
        '{12'h404, 32'h0000_0000, 12'h404, 32'h8000_000A, 1'b0},
        '{12'h406, 32'h8000_0001, 12'h405, 32'h8000_0001, 1'b0},
        '{12'h405, 32'h8000_0000, 12'h406, 32'h0000_0001, 1'b0},
        '{12'h408, 32'h0000_000C, 12'h407, 32'h0000_000C, 1'b0},
        '{12'h407, 32'h0000_0004, 12'h408, 32'h0000_0008, 1'b0},
        '{12'h408, 32'h8000_0001, 12'h408, 32'h8000_0009, 1'b1}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [N-1:0] v, input int n);
        evt_inc = v;
        repeat (n) @(negedge clk);
        evt_inc = '0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(12'h400, d); chk("R11 ctrl", 64'(d), 64'h2000);
        rd(12'h404, d); chk("R11 run mask", 64'(d), 0);
        rd(12'h406, d); chk("R11 ie mask", 64'(d), 0);
        rd(12'h408, d); chk("R11 ovf mask", 64'(d), 0);
        rd(12'h40A, d); chk("R11 cycle lo", 64'(d), 0);
        rd(12'h421, d); chk("R11 counter0", 64'(d), 0);
        chk("R11 irq", 64'(ovf_irq), 0);

        // R10 unmapped addresses
        wr(12'h401, 32'hFFFF_FFFF);
        wr(12'h430, 32'h1234_5678);
        rd(12'h401, d); chk("R10 hole read", 64'(d), 0);
        rd(12'h430, d); chk("R10 hole read 0x430", 64'(d), 0);
        rd(12'h400, d); chk("R10 ctrl untouched", 64'(d), 64'h2000);
        rd(12'h421, d); chk("R10 counter0 untouched", 64'(d), 0);
        rd(12'h431, d); chk("R10 counter1 untouched", 64'(d), 0);

        // R3 R4 R9 vector table
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v].wa, VEC[v].wd);
            rd(VEC[v].ra, d);
            chk($sformatf("R4 vector %0d", v), 64'(d), 64'(VEC[v].ex));
            chk($sformatf("R9 vector %0d irq", v), 64'(ovf_irq), 64'(VEC[v].irq));
        end
        wr(12'h403, 32'hFFFF_FFFF);
        wr(12'h405, 32'hFFFF_FFFF);
        wr(12'h407, 32'hFFFF_FFFF);
        rd(12'h408, d); chk("R4 clear all", 64'(d), 0);

        // R5 preload
        wr(12'h421, 32'h8000_0000);
        rd(12'h421, d); chk("R5 preload counter0", 64'(d), 64'h8000_0000);
        wr(12'h441, 32'hFFFF_FFFE);
        rd(12'h441, d); chk("R5 preload counter2", 64'(d), 64'hFFFF_FFFE);

        // R7 gating
        wr(12'h404, 32'h1);
        pulse(4'b0001, 3);
        rd(12'h421, d); chk("R7 no count while run bit clear", 64'(d), 64'h8000_0000);
        wr(12'h400, 32'h1);
        rd(12'h400, d); chk("R1 ctrl run readback", 64'(d), 64'h2001);
        pulse(4'b0010, 2);
        rd(12'h431, d); chk("R7 no count while mask bit clear", 64'(d), 0);
        pulse(4'b0001, 3);
        rd(12'h421, d); chk("R7 three strobes", 64'(d), 64'h8000_0003);
        wr(12'h400, 32'h0);
        pulse(4'b0001, 2);
        rd(12'h421, d); chk("R1 stop holds counter", 64'(d), 64'h8000_0003);

        // R8 R9 overflow on counter2
        wr(12'h404, 32'h4);
        wr(12'h406, 32'h4);
        wr(12'h400, 32'h1);
        pulse(4'b0100, 2);
        rd(12'h441, d); chk("R8 counter2 wrapped", 64'(d), 0);
        rd(12'h408, d); chk("R8 overflow bit2", 64'(d), 64'h4);
        chk("R9 irq raised", 64'(ovf_irq), 1);
        wr(12'h405, 32'h4);
        chk("R9 irq masked", 64'(ovf_irq), 0);
        wr(12'h406, 32'h4);
        chk("R9 irq unmasked", 64'(ovf_irq), 1);
        wr(12'h407, 32'h4);
        chk("R9 irq after clear", 64'(ovf_irq), 0);

        // R8 wrap beats a clear in the same cycle
        wr(12'h451, 32'hFFFF_FFFF);
        wr(12'h404, 32'h8);
        evt_inc = 4'b1000;
        reg_wr = 1'b1; reg_addr = 12'h407; reg_wdata = 32'h8;
        @(negedge clk);
        evt_inc = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(12'h408, d); chk("R8 set wins over clear", 64'(d), 64'h8);
        rd(12'h451, d); chk("R8 counter3 wrapped", 64'(d), 0);
        wr(12'h407, 32'h8);

        // R6 cycle counter: four counting edges from ...FFFC
        wr(12'h400, 32'h0);
        wr(12'h40A, 32'hFFFF_FFFC);
        wr(12'h40B, 32'hFFFF_FFFF);
        rd(12'h40A, d); chk("R6 cycle lo preload", 64'(d), 64'hFFFF_FFFC);
        rd(12'h40B, d); chk("R6 cycle hi preload", 64'(d), 64'hFFFF_FFFF);
        wr(12'h404, 32'h8000_0000);
        wr(12'h400, 32'h1);
        repeat (3) @(negedge clk);
        wr(12'h400, 32'h0);
        rd(12'h40A, d); chk("R6 cycle lo wrapped", 64'(d), 0);
        rd(12'h40B, d); chk("R6 cycle hi wrapped", 64'(d), 0);
        rd(12'h408, d); chk("R8 cycle overflow bit31", 64'(d), 64'h8000_0000);
        chk("R9 irq off, ie bit31 clear", 64'(ovf_irq), 0);
        wr(12'h406, 32'h8000_0000);
        chk("R9 irq on cycle overflow", 64'(ovf_irq), 1);
        repeat (2) @(negedge clk);
        rd(12'h40A, d); chk("R6 cycle holds when stopped", 64'(d), 0);

        // R2 reset commands
        wr(12'h40A, 32'h5);
        wr(12'h431, 32'h7);
        wr(12'h400, 32'h2);
        rd(12'h421, d); chk("R2 event reset counter0", 64'(d), 0);
        rd(12'h431, d); chk("R2 event reset counter1", 64'(d), 0);
        rd(12'h40A, d); chk("R2 cycle kept on event reset", 64'(d), 5);
        rd(12'h400, d); chk("R2 reset bits read zero", 64'(d), 64'h2000);
        wr(12'h400, 32'h4);
        rd(12'h40A, d); chk("R2 cycle reset", 64'(d), 0);
        wr(12'h431, 32'h7);
        wr(12'h40A, 32'h9);
        wr(12'h400, 32'h6);
        rd(12'h431, d); chk("R2 full reset counter1", 64'(d), 0);
        rd(12'h40A, d); chk("R2 full reset cycle", 64'(d), 0);
        wr(12'h40A, 32'h9);
        wr(12'h400, 32'h7);
        rd(12'h40A, d); chk("R2 reset beats counting", 64'(d), 0);
        @(negedge clk);
        rd(12'h40A, d); chk("R6 counts after reset", 64'(d), 1);
        wr(12'h400, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule